// File: doc/BRIEF.md
# VID Target Register Controller

This block sits behind the command decoder of a regulator's digital control port. It receives commands that have already been decoded: set a new voltage code, set a power state, write a register, read a register. It keeps a small bank of configuration and data registers, each at its own 8-bit index. Every command gets a 2-bit response code one cycle later. A read also returns one byte on a data bus in that same cycle.

From those registers the block works out the voltage code that the output should settle on. Before the first accepted set-voltage command, the output targets the boot code and ignores any margin. After it, the target is the programmed setting moved up or down by a sign-magnitude margin, kept between zero and the programmed ceiling. A ramp stage moves the output code one step toward the target on each tick pulse. It raises a settled flag once the output matches the target.

Top module: `vid_target_ctrl`

## Requirements
- R1: A synchronous reset sets the registers as follows: boot code (index 26h) to BOOT_RESET (00h by default), ceiling (30h) to FBh, setting (31h) to 00h, power state (32h) to 00h, margin (33h) to 00h, and multi-regulator configuration (34h) to 01h when `strap_second` is high or 00h when it is low. The same reset sets `vid_out` to 00h and selects boot mode.
- R2: Each command (`cmd_valid` high) produces `rsp_valid` high for exactly one cycle, on the cycle after the command. The codes are ACK=2'b01, NOT_SUPPORTED=2'b10 and REJECT=2'b11. `rsp_code` is 2'b00 whenever `rsp_valid` is low. Opcodes are 00 set-VID, 01 set power state, 10 register write, 11 register read.
- R3: A set-VID whose data is above the ceiling register answers NOT_SUPPORTED. It leaves the setting register and boot mode unchanged.
- R4: A set-VID at or below the ceiling answers ACK, loads the setting register (index 31h) and ends boot mode for good.
- R5: A set-power-state command loads its data into index 32h and answers ACK.
- R6: A write to index 26h, 30h, 31h, 32h, 33h or 34h loads that register and answers ACK. A read of one of these indices answers ACK and returns the register on `rd_data` in the cycle after the request.
- R7: A write or read at any other index answers REJECT. Such a write changes no register. Such a read returns 00h.
- R8: In boot mode, `target_vid` is the boot code, capped at the ceiling. The margin register has no effect in boot mode.
- R9: Outside boot mode, `target_vid` is the setting plus the margin's bits 6:0 when bit 7 is 0, or the setting minus them when bit 7 is 1. The result is clamped to the range 00h up to the ceiling. `target_vid` follows a register change one cycle later.
- R10: On each cycle with `ramp_tick` high, `vid_out` moves one code toward `target_vid`. Without a tick, `vid_out` holds.
- R11: `settled` is high exactly when `vid_out` equals `target_vid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_second | input | 1 | Selects the reset value of the multi-regulator configuration register |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Decoded opcode |
| cmd_idx | input | 8 | Register index for write and read |
| cmd_data | input | 8 | VID code, power state or write data |
| ramp_tick | input | 1 | Step pulse for the output ramp |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | Response code |
| rd_data | output | 8 | Read data |
| target_vid | output | 8 | Effective target code |
| vid_out | output | 8 | Ramped output code |
| settled | output | 1 | Output equals target |

## Verification
The assertions assume that `strap_second` is stable while reset is released. They also assume that a command strobe lasts one cycle per command. The bench drives every input on the falling edge and keeps the strap fixed across each reset. It ramps the output only after two quiet cycles, so the step checks compare against a target that has already settled. Set-VID data is drawn partly inside the current ceiling and partly across the full byte range, so that both the accepted and the rejected path are exercised.

// File: rtl/vid_tc_pkg.sv
package vid_tc_pkg;
  localparam int IDX_W = 8;
  localparam int NREG  = 6;

  typedef enum logic [1:0] {
    OP_SETVID = 2'b00,
    OP_SETPS  = 2'b01,
    OP_WRITE  = 2'b10,
    OP_READ   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_ACK    = 2'b01,
    RSP_NOSUP  = 2'b10,
    RSP_REJECT = 2'b11
  } rsp_e;

  // slot numbers inside the register bank
  localparam int SLOT_BOOT   = 0;
  localparam int SLOT_CEIL   = 1;
  localparam int SLOT_SET    = 2;
  localparam int SLOT_PSTATE = 3;
  localparam int SLOT_MARGIN = 4;
  localparam int SLOT_MULTI  = 5;

  localparam logic [IDX_W-1:0] SLOT_INDEX [NREG] = '{8'h26, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34};
endpackage

// File: rtl/vid_regbank.sv
module vid_regbank
  import vid_tc_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] BOOT_RESET = '0,
  parameter logic [DATA_W-1:0] CEIL_RESET = 8'hFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_second,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] boot_val,
  output logic [DATA_W-1:0] ceil_val,
  output logic [DATA_W-1:0] set_val,
  output logic [DATA_W-1:0] margin_val,
  output logic              boot_mode,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NREG];
  logic [NREG-1:0]   hit_vec;
  logic              setvid_ok;
  logic              any_hit;
  logic [DATA_W-1:0] rd_sel;

  assign setvid_ok = (cmd_op == OP_SETVID) && (cmd_data <= regs[SLOT_CEIL]);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DATA_W-1:0] FIXED_RV =
      (g == SLOT_BOOT) ? BOOT_RESET :
      (g == SLOT_CEIL) ? CEIL_RESET : '0;
    logic [DATA_W-1:0] slot_q;
    logic [DATA_W-1:0] rst_val;
    logic              we;

    assign hit_vec[g] = (cmd_idx == SLOT_INDEX[g]);
    assign rst_val    = (g == SLOT_MULTI) ? DATA_W'(strap_second) : FIXED_RV;

    always_comb begin
      we = 1'b0;
      if (cmd_valid) begin
        if (cmd_op == OP_WRITE && hit_vec[g])        we = 1'b1;
        if (g == SLOT_SET && setvid_ok)              we = 1'b1;
        if (g == SLOT_PSTATE && cmd_op == OP_SETPS)  we = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)     slot_q <= rst_val;
      else if (we) slot_q <= cmd_data;
    end

    assign regs[g] = slot_q;
  end

  assign any_hit = |hit_vec;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) rd_sel = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_mode <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rd_data   <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_code  <= RSP_NONE;
      if (cmd_valid) begin
        unique case (cmd_op)
          OP_SETVID: begin
            rsp_code <= setvid_ok ? RSP_ACK : RSP_NOSUP;
            if (setvid_ok) boot_mode <= 1'b0;
          end
          OP_SETPS: rsp_code <= RSP_ACK;
          OP_WRITE: rsp_code <= any_hit ? RSP_ACK : RSP_REJECT;
          OP_READ: begin
            rsp_code <= any_hit ? RSP_ACK : RSP_REJECT;
            rd_data  <= any_hit ? rd_sel : '0;
          end
          default: rsp_code <= RSP_NONE;
        endcase
      end
    end
  end

  assign boot_val   = regs[SLOT_BOOT];
  assign ceil_val   = regs[SLOT_CEIL];
  assign set_val    = regs[SLOT_SET];
  assign margin_val = regs[SLOT_MARGIN];
endmodule

// File: rtl/vid_margin.sv
module vid_margin #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_mode,
  input  logic [DATA_W-1:0] boot_val,
  input  logic [DATA_W-1:0] ceil_val,
  input  logic [DATA_W-1:0] set_val,
  input  logic [DATA_W-1:0] margin_val,
  output logic [DATA_W-1:0] target_q
);
  localparam int SUM_W = DATA_W + 2;

  logic signed [SUM_W-1:0] base_s;
  logic signed [SUM_W-1:0] mag_s;
  logic signed [SUM_W-1:0] ceil_s;
  logic signed [SUM_W-1:0] sum_s;
  logic [DATA_W-1:0]       margined;
  logic [DATA_W-1:0]       boot_capped;

  assign base_s = $signed({2'b00, set_val});
  assign mag_s  = $signed({3'b000, margin_val[DATA_W-2:0]});
  assign ceil_s = $signed({2'b00, ceil_val});
  assign sum_s  = margin_val[DATA_W-1] ? (base_s - mag_s) : (base_s + mag_s);

  always_comb begin
    if (sum_s < 0)            margined = '0;
    else if (sum_s > ceil_s)  margined = ceil_val;
    else                      margined = sum_s[DATA_W-1:0];
  end

  assign boot_capped = (boot_val > ceil_val) ? ceil_val : boot_val;

  always_ff @(posedge clk) begin
    if (rst) target_q <= '0;
    else     target_q <= boot_mode ? boot_capped : margined;
  end
endmodule

// File: rtl/vid_ramp.sv
module vid_ramp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ramp_tick,
  input  logic [DATA_W-1:0] target,
  output logic [DATA_W-1:0] vid_q,
  output logic              settled
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q <= '0;
    end else if (ramp_tick) begin
      if (vid_q < target)      vid_q <= vid_q + 1'b1;
      else if (vid_q > target) vid_q <= vid_q - 1'b1;
    end
  end

  assign settled = (vid_q == target);
endmodule

// File: rtl/vid_target_ctrl.sv
module vid_target_ctrl
  import vid_tc_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] BOOT_RESET = '0,
  parameter logic [DATA_W-1:0] CEIL_RESET = 8'hFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_second,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              ramp_tick,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] target_vid,
  output logic [DATA_W-1:0] vid_out,
  output logic              settled
);
  logic [DATA_W-1:0] boot_val;
  logic [DATA_W-1:0] ceil_val;
  logic [DATA_W-1:0] set_val;
  logic [DATA_W-1:0] margin_val;
  logic              boot_mode;

  vid_regbank #(
    .DATA_W(DATA_W), .BOOT_RESET(BOOT_RESET), .CEIL_RESET(CEIL_RESET)
  ) u_bank (
    .clk(clk), .rst(rst), .strap_second(strap_second),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .boot_val(boot_val), .ceil_val(ceil_val), .set_val(set_val),
    .margin_val(margin_val), .boot_mode(boot_mode),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rd_data(rd_data)
  );

  vid_margin #(.DATA_W(DATA_W)) u_margin (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .boot_val(boot_val),
    .ceil_val(ceil_val), .set_val(set_val), .margin_val(margin_val),
    .target_q(target_vid)
  );

  vid_ramp #(.DATA_W(DATA_W)) u_ramp (
    .clk(clk), .rst(rst), .ramp_tick(ramp_tick), .target(target_vid),
    .vid_q(vid_out), .settled(settled)
  );
endmodule

// File: rtl/vid_target_ctrl_chk.sv
module vid_target_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_idx,
  input logic [DATA_W-1:0] cmd_data,
  input logic              ramp_tick,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] target_vid,
  input logic [DATA_W-1:0] vid_out,
  input logic [DATA_W-1:0] ceil_val,
  input logic [DATA_W-1:0] set_val
);
  logic idx_listed;
  assign idx_listed = (cmd_idx == 8'h26) || (cmd_idx == 8'h30) || (cmd_idx == 8'h31) ||
                      (cmd_idx == 8'h32) || (cmd_idx == 8'h33) || (cmd_idx == 8'h34);

  p_rsp_after_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid && (rsp_code != 2'b00));

  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid && (rsp_code == 2'b00));

  p_over_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b00 && cmd_data > ceil_val) |=> (rsp_code == 2'b10) && $stable(set_val));

  p_unknown_read_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b11 && !idx_listed) |=> (rsp_code == 2'b11) && (rd_data == '0));

  p_target_capped_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> target_vid <= $past(ceil_val));

  p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !ramp_tick |=> $stable(vid_out));

  p_step_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (ramp_tick && vid_out != target_vid) |=>
      (vid_out == $past(vid_out) + 1'b1) || (vid_out == $past(vid_out) - 1'b1));
endmodule

bind vid_target_ctrl vid_target_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .cmd_data(cmd_data), .ramp_tick(ramp_tick), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rd_data(rd_data), .target_vid(target_vid), .vid_out(vid_out),
  .ceil_val(ceil_val), .set_val(set_val)
);

// File: tb/test_vid_target_ctrl.sv
module test_vid_target_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_second = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_idx = 8'h00;
  logic [7:0] cmd_data = 8'h00;
  logic       ramp_tick = 1'b0;
  logic       rsp_valid;
  logic [1:0] rsp_code;
  logic [7:0] rd_data;
  logic [7:0] target_vid;
  logic [7:0] vid_out;
  logic       settled;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the registers
  logic [7:0] m_boot, m_ceil, m_set, m_ps, m_margin, m_multi, m_vid;
  bit         m_bootmode;

  always #2.5 clk = ~clk;

  vid_target_ctrl i_vid_target_ctrl (
    .clk(clk), .rst(rst), .strap_second(strap_second), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data), .ramp_tick(ramp_tick),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rd_data(rd_data),
    .target_vid(target_vid), .vid_out(vid_out), .settled(settled)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_target();
    int v;
    if (m_bootmode) return (m_boot > m_ceil) ? m_ceil : m_boot;
    v = int'(m_set);
    if (m_margin[7]) v = v - int'(m_margin[6:0]);
    else             v = v + int'(m_margin[6:0]);
    if (v < 0) v = 0;
    if (v > int'(m_ceil)) v = int'(m_ceil);
    return 8'(v);
  endfunction

  function automatic bit idx_known(input logic [7:0] idx);
    return idx == 8'h26 || idx == 8'h30 || idx == 8'h31 || idx == 8'h32 ||
           idx == 8'h33 || idx == 8'h34;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] idx);
    case (idx)
      8'h26: return m_boot;
      8'h30: return m_ceil;
      8'h31: return m_set;
      8'h32: return m_ps;
      8'h33: return m_margin;
      8'h34: return m_multi;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_reset(input bit strap);
    @(negedge clk);
    strap_second = strap;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_boot = 8'h00; m_ceil = 8'hFB; m_set = 8'h00; m_ps = 8'h00;
    m_margin = 8'h00; m_multi = {7'b0, strap}; m_vid = 8'h00; m_bootmode = 1'b1;
  endtask

  // issue one command, check response, update model, then check target
  task automatic do_cmd(input logic [1:0] op, input logic [7:0] idx, input logic [7:0] data);
    logic [1:0] exp_code;
    logic [7:0] exp_rd;
    bit         is_read;
    is_read = 1'b0;
    exp_rd  = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = data;
    case (op)
      2'b00: begin
        if (data > m_ceil) exp_code = 2'b10;
        else begin exp_code = 2'b01; m_set = data; m_bootmode = 1'b0; end
      end
      2'b01: begin exp_code = 2'b01; m_ps = data; end
      2'b10: begin
        if (idx_known(idx)) begin
          exp_code = 2'b01;
          case (idx)
            8'h26: m_boot = data;
            8'h30: m_ceil = data;
            8'h31: m_set = data;
            8'h32: m_ps = data;
            8'h33: m_margin = data;
            default: m_multi = data;
          endcase
        end else exp_code = 2'b11;
      end
      default: begin
        is_read  = 1'b1;
        exp_code = idx_known(idx) ? 2'b01 : 2'b11;
        exp_rd   = model_read(idx);
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 rsp_valid", int'(rsp_valid), 1);
    if (op == 2'b00 && exp_code == 2'b10) check("R3 nosup code", int'(rsp_code), int'(exp_code));
    else if (op == 2'b01) check("R5 power state ack", int'(rsp_code), int'(exp_code));
    else if (exp_code == 2'b11) check("R7 reject code", int'(rsp_code), int'(exp_code));
    else check("R4 R6 ack code", int'(rsp_code), int'(exp_code));
    if (is_read) check("R6 R7 read data", int'(rd_data), int'(exp_rd));
    @(negedge clk);
    check("R2 rsp strobe one cycle", int'(rsp_valid), 0);
    check("R8 R9 target", int'(target_vid), int'(exp_target()));
    check("R10 no move without tick", int'(vid_out), int'(m_vid));
  endtask

  task automatic ramp(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ramp_tick = 1'b1;
      @(negedge clk);
      ramp_tick = 1'b0;
      if (m_vid < exp_target())      m_vid = m_vid + 8'd1;
      else if (m_vid > exp_target()) m_vid = m_vid - 8'd1;
      check("R10 ramp step", int'(vid_out), int'(m_vid));
      check("R11 settled", int'(settled), int'(m_vid == exp_target()));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1 reset values with strap high
    do_reset(1'b1);
    @(negedge clk);
    check("R1 vid_out reset", int'(vid_out), 0);
    check("R2 rsp idle", int'(rsp_valid), 0);
    do_cmd(2'b11, 8'h30, 8'h00);
    check("R1 ceiling reset", int'(rd_data), 8'hFB);
    do_cmd(2'b11, 8'h34, 8'h00);
    check("R1 multi strap high", int'(rd_data), 8'h01);
    do_cmd(2'b11, 8'h31, 8'h00);
    do_cmd(2'b11, 8'h32, 8'h00);
    do_cmd(2'b11, 8'h33, 8'h00);
    do_cmd(2'b11, 8'h26, 8'h00);
    do_reset(1'b0);
    do_cmd(2'b11, 8'h34, 8'h00);
    check("R1 multi strap low", int'(rd_data), 8'h00);

    // R8 boot hold ignores margin
    do_cmd(2'b10, 8'h26, 8'h40);
    do_cmd(2'b10, 8'h33, 8'h05);
    check("R8 boot target", int'(target_vid), 8'h40);
    ramp(70);
    // R3 above ceiling keeps boot mode
    do_cmd(2'b00, 8'h00, 8'hFC);
    do_cmd(2'b00, 8'h00, 8'hFF);
    check("R3 still boot", int'(target_vid), 8'h40);
    // R4 accept at ceiling exactly, margin then clamps to ceiling
    do_cmd(2'b00, 8'h00, 8'hFB);
    check("R9 high clamp", int'(target_vid), 8'hFB);
    // R9 negative margin saturates at zero
    do_cmd(2'b00, 8'h00, 8'h05);
    do_cmd(2'b10, 8'h33, 8'h8A);
    check("R9 low clamp", int'(target_vid), 8'h00);
    do_cmd(2'b10, 8'h33, 8'h83);
    check("R9 negative margin", int'(target_vid), 8'h02);
    // R7 unknown write leaves registers alone
    do_cmd(2'b10, 8'h35, 8'hAA);
    do_cmd(2'b10, 8'h00, 8'h55);
    do_cmd(2'b11, 8'h35, 8'h00);
    // lower ceiling below setting
    do_cmd(2'b00, 8'h00, 8'h80);
    do_cmd(2'b10, 8'h30, 8'h60);
    check("R9 ceiling lowered", int'(target_vid), 8'h60);
    ramp(120);

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [1:0] op;
      logic [7:0] idx, data;
      op = 2'($urandom % 4);
      if ($urandom % 10 < 7) begin
        case ($urandom % 6)
          0: idx = 8'h26; 1: idx = 8'h30; 2: idx = 8'h31;
          3: idx = 8'h32; 4: idx = 8'h33; default: idx = 8'h34;
        endcase
      end else idx = 8'($urandom);
      data = 8'($urandom);
      if (op == 2'b00 && ($urandom % 2 == 1)) data = 8'($urandom % (int'(m_ceil) + 1));
      if (op == 2'b10 && idx == 8'h30 && data < 8'h20) data = data + 8'h80;
      do_cmd(op, idx, data);
      if (i % 25 == 24) ramp(1 + int'($urandom % 300));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule